// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block supervises software by counting ticks of a slow 256 Hz time base. The count restarts only when software writes a two-byte key to the control register in the right order. An internal pointer flips on every control write and decides which byte of the key the next write is compared against. A mode register selects one of seven timeout lengths, expressed as terminal tick counts.

If the count reaches its terminal value with no valid key since the last clear, the block raises a one-cycle warning interrupt. If a second timeout follows with still no valid key, the block raises a reset request. That request stays high until the system reset pulls the block back to its idle state. Counting is held off until the slow clock reports that it is running, through a ready input.

Top module: `wdt_guard`

## Requirements
- R1: After reset the counter is zero, the pointer is 0, the mode is 000 (32 ticks), and `warn_irq` and `rst_req` are low.
- R2: The counter advances only on a clock cycle where `tick` and `slow_ready` are both high. Ticks while `slow_ready` is low have no effect on the timeout.
- R3: The first timeout with no valid key since the last clear pulses `warn_irq` high for exactly one clock cycle. That cycle is the one after the clock edge that sampled the terminal tick.
- R4: Mode codes select these terminal tick counts: 000=32, 001=128, 010=512, 011=2048, 100=6, 101=8, 110=16. A timeout happens on the terminal-count-th accepted tick after a clear.
- R5: A mode write (`wr_sel`=1) of code 111 in `wr_data[2:0]` is ignored, and the previous mode stays in force.
- R6: A control write (`wr_sel`=0) of 8'h5A with the pointer at 0, followed by a control write of 8'hA5 with the pointer at 1, clears the counter and the pending warning. The next timeout is therefore again only a warning.
- R7: The pointer inverts on every control write, whatever its value. A write that does not match the expected key byte breaks the sequence and leaves the counter running.
- R8: A second timeout with no valid key since the first raises `rst_req`, which then stays high until reset.
- R9: A timeout returns the pointer to 0 and discards a half-entered key.
- R10: If the mode is shortened below the current count, the next accepted tick causes a timeout.
- R11: When a completing key write and an accepted tick fall in the same cycle, the clear wins and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| slow_ready | input | 1 | High once the slow time-base clock is running |
| tick | input | 1 | One-cycle 256 Hz time-base tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 control/key, 1 mode |
| wr_data | input | 8 | Write data; mode uses bits 2:0 |
| warn_irq | output | 1 | One-cycle warning interrupt on the first timeout |
| rst_req | output | 1 | Sticky system-reset request on the second timeout |

## Verification
Every legal mode is swept to its first and second timeout. The bench counts ticks one by one, so an off-by-one terminal count, a wrong table entry, or a broken warning-then-reset order each shows up in a different tick.

Key sequences are tried in several forms:
- the correct pair;
- wrong bytes in either slot;
- a pair preceded by two junk writes, which tests pointer toggling;
- a pair split by a timeout, which tests the pointer return.

Each sequence is judged only by when the next timeout arrives and what kind it is. Further patterns cover the following:
- ticks while the slow clock is not ready;
- a prohibited mode write;
- a mode shortened under the running count;
- a key completion in the same cycle as a tick.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
    localparam int KEY_W  = 8;
    localparam int MODE_W = 3;

    localparam logic [KEY_W-1:0]  KEY_ARM  = 8'h5A;
    localparam logic [KEY_W-1:0]  KEY_FIRE = 8'hA5;
    localparam logic [MODE_W-1:0] MODE_BAD = 3'b111;

    typedef enum logic {
        SEL_CTL  = 1'b0,
        SEL_MODE = 1'b1
    } wsel_e;

    // key tracker state: expected-byte pointer and "first byte matched" flag
    typedef struct packed {
        logic ptr;
        logic armed;
    } key_st_t;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [KEY_W-1:0] wr_data,
    input  logic             ovf,
    output logic             key_ok
);
    key_st_t key_d, key_q;

    always_comb begin
        key_d  = key_q;
        key_ok = 1'b0;
        if (ctl_wr) begin
            if (!key_q.ptr) begin
                key_d.armed = (wr_data == KEY_ARM);
            end else begin
                key_ok      = key_q.armed && (wr_data == KEY_FIRE);
                key_d.armed = 1'b0;
            end
            key_d.ptr = ~key_q.ptr;
        end
        // a timeout abandons any half-entered key
        if (ovf) begin
            key_d.ptr   = 1'b0;
            key_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_q <= '0;
        else        key_q <= key_d;
    end

    // R9: pointer back to 0 after a timeout
    p_ovf_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !key_q.ptr);

    // R7: every control write flips the pointer unless a timeout overrides it
    p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ovf) |=> (key_q.ptr != $past(key_q.ptr)));

    // R6: a completed key leaves nothing armed
    p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_ok |=> (!key_q.armed && !key_q.ptr));
endmodule

// File: rtl/wdt_mode_reg.sv
module wdt_mode_reg
    import wdt_guard_pkg::*;
#(
    parameter int              TBASE_LOG2 = 5,
    parameter int              LONG_STEP  = 2,
    parameter int              SHORT_A    = 6,
    parameter int              SHORT_B    = 8,
    parameter int              SHORT_C    = 16,
    parameter int              CNT_W      = 12,
    parameter logic [MODE_W-1:0] RST_MODE = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_in,
    output logic [CNT_W-1:0]  term
);
    localparam int N_CODES = 1 << MODE_W;
    localparam int N_LONG  = 4;

    logic [MODE_W-1:0] mode_d, mode_q;
    logic [CNT_W-1:0]  lut [N_CODES];

    for (genvar g = 0; g < N_CODES; g++) begin : g_lut
        if (g < N_LONG) begin : g_long
            localparam int TV = 1 << (TBASE_LOG2 + g * LONG_STEP);
            assign lut[g] = CNT_W'(TV);
        end else if (g == N_LONG) begin : g_sa
            assign lut[g] = CNT_W'(SHORT_A);
        end else if (g == N_LONG + 1) begin : g_sb
            assign lut[g] = CNT_W'(SHORT_B);
        end else if (g == N_LONG + 2) begin : g_sc
            assign lut[g] = CNT_W'(SHORT_C);
        end else begin : g_bad
            assign lut[g] = '1;
        end
    end

    always_comb begin
        mode_d = mode_q;
        if (mode_wr && (mode_in != MODE_BAD)) mode_d = mode_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= RST_MODE;
        else        mode_q <= mode_d;
    end

    assign term = lut[mode_q];

    // R5: the prohibited code never lands in the register
    p_mode_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != MODE_BAD);

    // R5: writing the prohibited code leaves the mode untouched
    p_mode_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_in == MODE_BAD) |=> $stable(mode_q));
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             key_ok,
    input  logic [CNT_W-1:0] term,
    output logic             ovf,
    output logic             warn_irq,
    output logic             rst_req
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             warned;
        logic             irq;
        logic             rreq;
    } esc_st_t;

    esc_st_t          esc_d, esc_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        esc_d     = esc_q;
        esc_d.irq = 1'b0;
        ovf       = 1'b0;
        cnt_inc   = esc_q.cnt + 1'b1;
        if (key_ok) begin
            esc_d.cnt    = '0;
            esc_d.warned = 1'b0;
        end else if (tick_en) begin
            if (cnt_inc >= term) begin
                ovf       = 1'b1;
                esc_d.cnt = '0;
                if (!esc_q.warned) begin
                    esc_d.warned = 1'b1;
                    esc_d.irq    = 1'b1;
                end else begin
                    esc_d.rreq = 1'b1;
                end
            end else begin
                esc_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) esc_q <= '0;
        else        esc_q <= esc_d;
    end

    assign warn_irq = esc_q.irq;
    assign rst_req  = esc_q.rreq;

    // R2: no accepted tick and no clear -> count holds
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !key_ok) |=> $stable(esc_q.cnt));

    // R3: the warning is a single-cycle pulse
    p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        warn_irq |=> !warn_irq);

    // R6: a valid key empties the counter and the pending warning
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_ok |=> (esc_q.cnt == '0 && !esc_q.warned));

    // R8: reset request is sticky
    p_rst_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    // R8: a reset request is only reached through a prior warning
    p_rst_after_warn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> esc_q.warned);
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int                TBASE_LOG2 = 5,
    parameter int                LONG_STEP  = 2,
    parameter int                SHORT_A    = 6,
    parameter int                SHORT_B    = 8,
    parameter int                SHORT_C    = 16,
    parameter logic [MODE_W-1:0] RST_MODE   = 3'b000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_ready,
    input  logic             tick,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [KEY_W-1:0] wr_data,
    output logic             warn_irq,
    output logic             rst_req
);
    localparam int MAX_TERM = 1 << (TBASE_LOG2 + (4 - 1) * LONG_STEP);
    localparam int CNT_W    = $clog2(MAX_TERM + 1);

    logic             tick_en;
    logic             ctl_wr;
    logic             mode_wr;
    logic             key_ok;
    logic             ovf;
    logic [CNT_W-1:0] term;

    assign tick_en = tick && slow_ready;
    assign ctl_wr  = wr_en && (wsel_e'(wr_sel) == SEL_CTL);
    assign mode_wr = wr_en && (wsel_e'(wr_sel) == SEL_MODE);

    wdt_key_seq u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (ctl_wr),
        .wr_data (wr_data),
        .ovf     (ovf),
        .key_ok  (key_ok)
    );

    wdt_mode_reg #(
        .TBASE_LOG2 (TBASE_LOG2),
        .LONG_STEP  (LONG_STEP),
        .SHORT_A    (SHORT_A),
        .SHORT_B    (SHORT_B),
        .SHORT_C    (SHORT_C),
        .CNT_W      (CNT_W),
        .RST_MODE   (RST_MODE)
    ) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (mode_wr),
        .mode_in (wr_data[MODE_W-1:0]),
        .term    (term)
    );

    wdt_escalate #(
        .CNT_W (CNT_W)
    ) u_esc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .key_ok   (key_ok),
        .term     (term),
        .ovf      (ovf),
        .warn_irq (warn_irq),
        .rst_req  (rst_req)
    );

    // R11: a clear and a timeout never coincide
    p_clear_beats_ovf_r11: assert property (@(posedge clk) disable iff (!rst_n)
        key_ok |-> !ovf);

    // R1: outputs quiet in the first cycle after reset release
    p_quiet_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!warn_irq && !rst_req));
endmodule

// File: tb/sim_wdt_guard.sv
module sim_wdt_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_ready = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       warn_irq;
    logic       rst_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    wdt_guard u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_ready (slow_ready),
        .tick       (tick),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .warn_irq   (warn_irq),
        .rst_req    (rst_req)
    );

    function automatic int exp_term(int m);
        if (m < 4)  return 32 << (2 * m);
        if (m == 4) return 6;
        if (m == 5) return 8;
        return 16;
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; slow_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic one_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // n ticks, each followed by a check that both outputs stay low
    task automatic quiet_ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            one_tick();
            chk(warn_irq, 1'b0, tag);
            chk(rst_req, 1'b0, tag);
        end
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state and default 32-tick mode
        do_reset();
        chk(warn_irq, 1'b0, "R1 irq after reset");
        chk(rst_req, 1'b0, "R1 rst_req after reset");
        quiet_ticks(31, "R1 default mode");
        one_tick();
        chk(warn_irq, 1'b1, "R1 default mode timeout");

        // R4 / R3 / R8: sweep every legal mode through both timeouts
        for (int m = 0; m < 7; m++) begin
            do_reset();
            wr(1'b1, 8'(m));
            quiet_ticks(exp_term(m) - 1, "R4 before first timeout");
            one_tick();
            chk(warn_irq, 1'b1, "R3 warning at terminal tick");
            chk(rst_req, 1'b0, "R3 no reset on first timeout");
            @(negedge clk);
            chk(warn_irq, 1'b0, "R3 warning lasts one cycle");
            quiet_ticks(exp_term(m) - 1, "R8 before second timeout");
            one_tick();
            chk(rst_req, 1'b1, "R8 reset on second timeout");
            chk(warn_irq, 1'b0, "R8 no second warning");
            for (int k = 0; k < 3; k++) begin
                one_tick();
                chk(rst_req, 1'b1, "R8 reset request sticky");
            end
        end

        // R5: prohibited code keeps the 6-tick mode
        do_reset();
        wr(1'b1, 8'h04);
        wr(1'b1, 8'h07);
        quiet_ticks(5, "R5 prohibited mode ignored");
        one_tick();
        chk(warn_irq, 1'b1, "R5 timeout still at 6");

        // R2: ticks without slow_ready do not count
        do_reset();
        wr(1'b1, 8'h04);
        slow_ready = 1'b0;
        quiet_ticks(10, "R2 ticks masked");
        slow_ready = 1'b1;
        repeat (20) @(negedge clk);
        chk(warn_irq, 1'b0, "R2 idle cycles");
        quiet_ticks(5, "R2 counting resumed");
        one_tick();
        chk(warn_irq, 1'b1, "R2 timeout after 6 accepted ticks");

        // R6: valid key clears counter and the pending warning
        do_reset();
        wr(1'b1, 8'h04);
        quiet_ticks(5, "R6 pre-key");
        wr(1'b0, 8'h5A);
        wr(1'b0, 8'hA5);
        quiet_ticks(5, "R6 counter restarted");
        one_tick();
        chk(warn_irq, 1'b1, "R6 warning after clear");
        quiet_ticks(4, "R6 after warning");
        wr(1'b0, 8'h5A);
        wr(1'b0, 8'hA5);
        quiet_ticks(5, "R6 warning state cleared");
        one_tick();
        chk(warn_irq, 1'b1, "R6 next timeout is a warning");
        chk(rst_req, 1'b0, "R6 next timeout not a reset");

        // R7: junk writes toggle pointer; wrong byte breaks the key
        do_reset();
        wr(1'b1, 8'h04);
        quiet_ticks(3, "R7 pre");
        wr(1'b0, 8'h11);
        wr(1'b0, 8'h22);
        wr(1'b0, 8'h5A);
        wr(1'b0, 8'hA5);
        quiet_ticks(5, "R7 key after two junk writes clears");
        one_tick();
        chk(warn_irq, 1'b1, "R7 warning");
        quiet_ticks(2, "R7 post warning");
        wr(1'b0, 8'h5A);
        wr(1'b0, 8'h33);
        wr(1'b0, 8'hA5);
        quiet_ticks(3, "R7 broken key does not clear");
        one_tick();
        chk(rst_req, 1'b1, "R7 broken key leads to reset");

        // R9: timeout between the two key bytes discards the first
        do_reset();
        wr(1'b1, 8'h04);
        quiet_ticks(5, "R9 pre");
        wr(1'b0, 8'h5A);
        one_tick();
        chk(warn_irq, 1'b1, "R9 timeout mid-key");
        wr(1'b0, 8'hA5);
        quiet_ticks(5, "R9 second byte rejected");
        one_tick();
        chk(rst_req, 1'b1, "R9 reset since key was discarded");

        // R10: shortening the mode below the running count
        do_reset();
        quiet_ticks(20, "R10 long mode");
        wr(1'b1, 8'h04);
        one_tick();
        chk(warn_irq, 1'b1, "R10 immediate timeout");

        // R11: key completion coincides with a tick
        do_reset();
        wr(1'b1, 8'h04);
        quiet_ticks(5, "R11 pre");
        wr(1'b0, 8'h5A);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'hA5; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        chk(warn_irq, 1'b0, "R11 clear wins over tick");
        quiet_ticks(5, "R11 tick not counted");
        one_tick();
        chk(warn_irq, 1'b1, "R11 timeout 6 ticks after clear");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule